// File: doc/BRIEF.md
# Flash XIP Request Window Classifier

The classifier sits between the system bus and a two-way execute-in-place cache with its serial flash engine behind it. Every incoming request carries an address, a security flag and a write flag. The block reads the window bits near the top of the address and applies a small control register to that window. From these it routes the request to one of four paths: a cache lookup, a direct path to the serial flash engine that skips the cache, a cache maintenance operation, or a bus error. When the cache is split by security state, it also names the way the request must use. It turns writes to chip-select regions that are not marked writable into reads. The cache arrays, the tag comparison and the serial engine itself are outside the block.

Requests enter on a valid/ready stream. Each accepted request comes out one cycle later on a registered valid/ready result stream. The result holds still while the consumer stalls. A new request is accepted only when the result register is empty or is being drained in that same cycle, so `req_ready` is `!res_valid || res_ready`. The control register is written and read on a plain side port. Only secure writers may change it.

Top module: `xip_window_classifier`

## Requirements
- R1: Address bits [27:26] select the window: 0 cached, 1 uncached, 2 maintenance, 3 uncached-untranslated. Exactly one bit of `res_route` is set on a valid result, encoded bit0 cache, bit1 bypass (direct to flash engine), bit2 maintenance, bit3 bus error.
- R2: A cached-window request routes to cache only if the cache enable of its own security state is set (control bit 0 secure, bit 1 non-secure); otherwise it routes to bypass.
- R3: Requests to the uncached and untranslated windows never route to cache, whatever the enables say.
- R4: Uncached-window errors are enabled per state (bit 3 secure, bit 4 non-secure), and untranslated-window errors separately (bit 5 secure, bit 6 non-secure). A blocked request routes to error, an unblocked one to bypass, and blocking one window leaves the other open.
- R5: A maintenance-window request routes to maintenance, except a non-secure one while the non-secure maintenance permit (bit 7) is 0, which routes to error.
- R6: A control write with the power-down bit (bit 2) set stores both cache enables as 0 in that same write. Clearing power-down lets the enables be written again.
- R7: With the split bit (bit 8) set, cache-routed requests have `res_way_forced`=1, with way 0 for secure and way 1 for non-secure. Otherwise `res_way_forced`=0 and `res_way`=0.
- R8: Bit 24 selects chip select 0 or 1, whose writable bits are bit 9 and bit 10 (both 0 after reset). A write to a non-writable select, or with address bit 25 set (no select), comes out with `res_write`=0 and the same route it would have had. Maintenance writes are never downgraded.
- R9: The control register is 11 bits, laid out as in R2 to R8, and reads back on `cfg_rdata` the cycle after a write. Writes with `cfg_secure`=0 are ignored.
- R10: `res_cs` and `res_offset` carry address bit 24 and bits [23:0] on every non-error result. An error result has offset 0 and `res_write` 0.
- R11: A result appears on the cycle after acceptance and stays unchanged while `res_ready` is 0. `req_ready` is low exactly while a result waits unconsumed.
- R12: After reset the control register reads 0, `res_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_addr | input | ADDR_W (28) | Request address within the XIP space |
| req_secure | input | 1 | Requester is secure |
| req_write | input | 1 | Request is a write |
| res_valid | output | 1 | Classified result present |
| res_ready | input | 1 | Consumer takes the result |
| res_route | output | 4 | One-hot route: cache, bypass, maintenance, error |
| res_way | output | 1 | Cache way to use when forced |
| res_way_forced | output | 1 | Way choice is mandatory |
| res_write | output | 1 | Write flag after downgrade |
| res_cs | output | 1 | Chip select |
| res_offset | output | OFFS_W (24) | Device offset |
| cfg_wen | input | 1 | Control register write strobe |
| cfg_secure | input | 1 | Control writer is secure |
| cfg_wdata | input | 11 | Control write data |
| cfg_rdata | output | 11 | Control register contents |

## Verification
The bench walks every control setting with power-down clear, across all windows, both security states, both write flags and both chip selects. This catches a design that mixes up the two states' enables, or that lets an untranslated block leak into the uncached window. It also catches a design that downgrades writes on the wrong chip select. Directed cases go after the power-down side effect, where a design that stored the enables as written would report a cache it cannot use. Others cover ignored non-secure control writes, which a design without the security gate would accept. The last covers a result stalled under back-pressure, which a design with a wrong ready would overwrite or drop.

// File: rtl/xwc_pkg.sv
package xwc_pkg;
  localparam int CTRL_W = 11;

  typedef enum logic [1:0] {
    WIN_CACHED   = 2'd0,
    WIN_UNCACHED = 2'd1,
    WIN_MAINT    = 2'd2,
    WIN_RAW      = 2'd3
  } win_e;

  typedef enum logic [3:0] {
    RT_CACHE  = 4'b0001,
    RT_BYPASS = 4'b0010,
    RT_MAINT  = 4'b0100,
    RT_ERR    = 4'b1000
  } route_e;

  // Field order is MSB first; bit 0 is en_s.
  typedef struct packed {
    logic wr_cs1;
    logic wr_cs0;
    logic way_split;
    logic maint_ns_ok;
    logic blk_raw_ns;
    logic blk_raw_s;
    logic blk_unc_ns;
    logic blk_unc_s;
    logic pwr_dn;
    logic en_ns;
    logic en_s;
  } ctrl_t;

  typedef struct packed {
    route_e route;
    logic   way;
    logic   way_forced;
    logic   write;
  } decision_t;

  localparam int DEC_W = $bits(decision_t);
endpackage

// File: rtl/xwc_ctrl_reg.sv
module xwc_ctrl_reg
  import xwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wen,
  input  logic              cfg_secure,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output ctrl_t             ctrl
);
  ctrl_t wr_val;

  always_comb begin
    wr_val = ctrl_t'(cfg_wdata);
    // Power-down cannot coexist with an enabled cache.
    if (wr_val.pwr_dn) begin
      wr_val.en_s  = 1'b0;
      wr_val.en_ns = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (cfg_wen && cfg_secure) ctrl <= wr_val;
  end
endmodule

// File: rtl/xwc_decode.sv
module xwc_decode
  import xwc_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int OFFS_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              secure,
  input  logic              write,
  input  ctrl_t             ctrl,
  output decision_t         dec,
  output logic              cs,
  output logic [OFFS_W-1:0] offset
);
  localparam int WIN_LSB = ADDR_W - 2;
  localparam int CS_BIT  = OFFS_W;
  localparam int HI_LSB  = OFFS_W + 1;
  localparam int HI_W    = WIN_LSB - HI_LSB;

  win_e            win;
  logic [HI_W-1:0] hi_bits;
  logic            cache_on, unc_blk, raw_blk, maint_ok, region_wr;
  route_e          route;

  assign win     = win_e'(addr[ADDR_W-1:WIN_LSB]);
  assign hi_bits = addr[WIN_LSB-1:HI_LSB];

  always_comb begin
    cache_on  = (secure ? ctrl.en_s : ctrl.en_ns) && !ctrl.pwr_dn;
    unc_blk   = secure ? ctrl.blk_unc_s : ctrl.blk_unc_ns;
    raw_blk   = secure ? ctrl.blk_raw_s : ctrl.blk_raw_ns;
    maint_ok  = secure || ctrl.maint_ns_ok;
    region_wr = (hi_bits == '0) &&
                (addr[CS_BIT] ? ctrl.wr_cs1 : ctrl.wr_cs0);

    unique case (win)
      WIN_CACHED:   route = cache_on ? RT_CACHE : RT_BYPASS;
      WIN_UNCACHED: route = unc_blk  ? RT_ERR   : RT_BYPASS;
      WIN_RAW:      route = raw_blk  ? RT_ERR   : RT_BYPASS;
      default:      route = maint_ok ? RT_MAINT : RT_ERR;
    endcase

    dec.route      = route;
    dec.way_forced = (route == RT_CACHE) && ctrl.way_split;
    dec.way        = dec.way_forced && !secure;
    unique case (route)
      RT_ERR:   dec.write = 1'b0;
      RT_MAINT: dec.write = write;
      default:  dec.write = write && region_wr;
    endcase

    cs     = (route == RT_ERR) ? 1'b0 : addr[CS_BIT];
    offset = (route == RT_ERR) ? '0   : addr[OFFS_W-1:0];
  end
endmodule

// File: rtl/xwc_out_stage.sv
module xwc_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xip_window_classifier.sv
module xip_window_classifier
  import xwc_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int OFFS_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_secure,
  input  logic              req_write,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [3:0]        res_route,
  output logic              res_way,
  output logic              res_way_forced,
  output logic              res_write,
  output logic              res_cs,
  output logic [OFFS_W-1:0] res_offset,
  input  logic              cfg_wen,
  input  logic              cfg_secure,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata
);
  localparam int PAY_W = DEC_W + 1 + OFFS_W;

  ctrl_t             ctrl;
  decision_t         dec, dec_q;
  logic              cs_d;
  logic [OFFS_W-1:0] off_d;
  logic [PAY_W-1:0]  pay_d, pay_q;

  xwc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wen(cfg_wen), .cfg_secure(cfg_secure),
    .cfg_wdata(cfg_wdata), .ctrl(ctrl)
  );

  xwc_decode #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_dec (
    .addr(req_addr), .secure(req_secure), .write(req_write), .ctrl(ctrl),
    .dec(dec), .cs(cs_d), .offset(off_d)
  );

  assign pay_d = {dec, cs_d, off_d};

  xwc_out_stage #(.W(PAY_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pay_d),
    .out_valid(res_valid), .out_ready(res_ready), .out_data(pay_q)
  );

  assign {dec_q, res_cs, res_offset} = pay_q;
  assign res_route      = dec_q.route;
  assign res_way        = dec_q.way;
  assign res_way_forced = dec_q.way_forced;
  assign res_write      = dec_q.write;
  assign cfg_rdata      = ctrl;
endmodule

// File: rtl/xwc_checker.sv
module xwc_checker #(
  parameter int ADDR_W = 28,
  parameter int OFFS_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              res_valid,
  input logic              res_ready,
  input logic [3:0]        res_route,
  input logic              res_way,
  input logic              res_way_forced,
  input logic              res_write,
  input logic              res_cs,
  input logic [OFFS_W-1:0] res_offset,
  input logic              cfg_wen,
  input logic              cfg_secure,
  input logic [10:0]       cfg_rdata
);
  // R1
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones(res_route) == 1);

  // R3
  no_cache_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[ADDR_W-1:ADDR_W-2] != 2'd0) |=> !res_route[0]);

  // R6
  pd_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[2] |-> cfg_rdata[1:0] == 2'b00);

  // R7
  forced_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_way_forced) |-> res_route == 4'b0001);

  // R9
  ns_cfg_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wen && !cfg_secure) |=> $stable(cfg_rdata));

  // R10
  err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_route[3]) |-> (res_offset == '0 && !res_write && !res_cs));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_route) && $stable(res_way)
      && $stable(res_way_forced) && $stable(res_write) && $stable(res_offset)));

  // R11
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !req_ready);
endmodule

bind xip_window_classifier xwc_checker #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .res_valid(res_valid), .res_ready(res_ready),
  .res_route(res_route), .res_way(res_way), .res_way_forced(res_way_forced),
  .res_write(res_write), .res_cs(res_cs), .res_offset(res_offset),
  .cfg_wen(cfg_wen), .cfg_secure(cfg_secure), .cfg_rdata(cfg_rdata)
);

// File: tb/xip_window_classifier_tb.sv
module xip_window_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_secure = 1'b0, req_write = 1'b0;
  logic [27:0] req_addr = '0;
  logic        req_ready, res_valid, res_way, res_way_forced, res_write, res_cs;
  logic        res_ready = 1'b1;
  logic [3:0]  res_route;
  logic [23:0] res_offset;
  logic        cfg_wen = 1'b0, cfg_secure = 1'b0;
  logic [10:0] cfg_wdata = '0, cfg_rdata;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  xip_window_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_secure(req_secure), .req_write(req_write),
    .res_valid(res_valid), .res_ready(res_ready), .res_route(res_route),
    .res_way(res_way), .res_way_forced(res_way_forced), .res_write(res_write),
    .res_cs(res_cs), .res_offset(res_offset), .cfg_wen(cfg_wen),
    .cfg_secure(cfg_secure), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  // {ctrl, addr, secure, write, route, way, forced, write_out}
  localparam logic [47:0] VECS [14] = '{
    {11'h001, 28'h0000100, 1'b1, 1'b0, 4'h1, 1'b0, 1'b0, 1'b0}, // R2 secure hit
    {11'h001, 28'h0000100, 1'b0, 1'b0, 4'h2, 1'b0, 1'b0, 1'b0}, // R2 ns bypass
    {11'h003, 28'h4000100, 1'b1, 1'b0, 4'h2, 1'b0, 1'b0, 1'b0}, // R3 uncached
    {11'h008, 28'h4000100, 1'b1, 1'b0, 4'h8, 1'b0, 1'b0, 1'b0}, // R4 block unc
    {11'h008, 28'hC000100, 1'b1, 1'b0, 4'h2, 1'b0, 1'b0, 1'b0}, // R4 raw open
    {11'h040, 28'hC000000, 1'b0, 1'b0, 4'h8, 1'b0, 1'b0, 1'b0}, // R4 raw ns blk
    {11'h000, 28'h8000000, 1'b0, 1'b1, 4'h8, 1'b0, 1'b0, 1'b0}, // R5 ns denied
    {11'h080, 28'h8000000, 1'b0, 1'b1, 4'h4, 1'b0, 1'b0, 1'b1}, // R5 ns permit
    {11'h103, 28'h0000000, 1'b0, 1'b0, 4'h1, 1'b1, 1'b1, 1'b0}, // R7 ns way1
    {11'h103, 28'h0000000, 1'b1, 1'b0, 4'h1, 1'b0, 1'b1, 1'b0}, // R7 s way0
    {11'h200, 28'h0000000, 1'b1, 1'b1, 4'h2, 1'b0, 1'b0, 1'b1}, // R8 cs0 wr
    {11'h200, 28'h1000000, 1'b1, 1'b1, 4'h2, 1'b0, 1'b0, 1'b0}, // R8 cs1 ro
    {11'h400, 28'h5000000, 1'b0, 1'b1, 4'h2, 1'b0, 1'b0, 1'b1}, // R8 mirror
    {11'h600, 28'h2000000, 1'b1, 1'b1, 4'h2, 1'b0, 1'b0, 1'b0}  // R8 no cs
  };

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Expected {route, way, forced, write} from the requirements.
  function automatic logic [6:0] expect_dec(logic [10:0] c, logic [27:0] a,
                                           logic s, logic w);
    logic [3:0] r;
    logic f, wy, wo;
    case (a[27:26])
      2'd0: r = ((s ? c[0] : c[1]) && !c[2]) ? 4'h1 : 4'h2;
      2'd1: r = (s ? c[3] : c[4]) ? 4'h8 : 4'h2;
      2'd3: r = (s ? c[5] : c[6]) ? 4'h8 : 4'h2;
      default: r = (s || c[7]) ? 4'h4 : 4'h8;
    endcase
    f  = (r == 4'h1) && c[8];
    wy = f && !s;
    if (r == 4'h8) wo = 1'b0;
    else if (r == 4'h4) wo = w;
    else wo = w && !a[25] && (a[24] ? c[10] : c[9]);
    return {r, wy, f, wo};
  endfunction

  task automatic cfg_write(logic [10:0] d, logic sec);
    req_valid  = 1'b0;
    cfg_wen    = 1'b1;
    cfg_wdata  = d;
    cfg_secure = sec;
    @(negedge clk);
    cfg_wen = 1'b0;
  endtask

  // Drive at a falling edge; result sampled at the next falling edge.
  task automatic apply(string req, logic [10:0] c, logic [27:0] a, logic s, logic w);
    logic [6:0] e;
    e = expect_dec(c, a, s, w);
    req_addr = a; req_secure = s; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    check(req, "valid", res_valid, 1);
    check(req, "route/way/forced/write", {res_route, res_way, res_way_forced, res_write}, e);
    check("R10", "cs/offset", {res_cs, res_offset},
          (e[6:3] == 4'h8) ? 0 : {a[24], a[23:0]});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "cfg_rdata", cfg_rdata, 0);
    check("R12", "res_valid", res_valid, 0);
    check("R12", "req_ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 power-down clears enables in the same write
    cfg_write(11'h007, 1'b1);
    check("R6", "pd write", cfg_rdata, 11'h004);
    apply("R6", 11'h004, 28'h0000040, 1'b1, 1'b0);
    cfg_write(11'h003, 1'b1);
    check("R6", "re-enable", cfg_rdata, 11'h003);
    // R9 non-secure write ignored
    cfg_write(11'h7F8, 1'b0);
    check("R9", "ns write", cfg_rdata, 11'h003);
    apply("R9", 11'h003, 28'h0000040, 1'b0, 1'b0);

    // Table walk (R1..R8)
    foreach (VECS[i]) begin
      cfg_write(VECS[i][47:37], 1'b1);
      apply("R1", VECS[i][47:37], VECS[i][36:9], VECS[i][8], VECS[i][7]);
      check("R1", "table", {res_route, res_way, res_way_forced, res_write}, VECS[i][6:0]);
    end

    // R11 back-pressure
    cfg_write(11'h001, 1'b1);
    res_ready = 1'b0;
    req_addr = 28'h0000123; req_secure = 1'b1; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    check("R11", "first valid", res_valid, 1);
    check("R11", "ready low", req_ready, 0);
    req_addr = 28'h4000456; req_secure = 1'b0;
    @(negedge clk);
    check("R11", "held route", res_route, 4'h1);
    check("R11", "held offset", res_offset, 24'h000123);
    res_ready = 1'b1;
    @(negedge clk);
    check("R11", "next route", res_route, 4'h2);
    check("R11", "next offset", res_offset, 24'h000456);
    req_valid = 1'b0;
    @(negedge clk);
    check("R11", "drained", res_valid, 0);

    // Exhaustive sweep, power-down clear (R1..R5, R7, R8, R10)
    for (int k = 0; k < 1024; k++) begin
      logic [10:0] c;
      c = {k[9:2], 1'b0, k[1:0]};
      cfg_write(c, 1'b1);
      for (int j = 0; j < 32; j++) begin
        logic [27:0] a;
        a = {j[4:3], 1'b0, j[0], 24'h5A5A00 ^ 24'(k)};
        apply("R2", c, a, j[2], j[1]);
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule